// File: doc/BRIEF.md
# PLL Coefficient Search Engine

This block works out divider settings for a synthesizer PLL. Given a requested output rate and the reference clock rate, both in kHz, it searches for a reference divider M, a feedback multiplier N and a post-divider code PL so that the synthesized rate comes as close to the request as possible. Every candidate must respect the limits on the VCO frequency, the comparison frequency (reference divided by M), M and N. The result is the chosen M, N and PL, the achieved rate, an exact-match flag and a flag that reports when no candidate was valid.

The engine visits one candidate per step. A single shared restoring divider performs every division, so each division costs a fixed number of cycles. A host pulses `start` with the two rates. It then waits for the one-cycle `done` pulse and reads the results, which hold until the next accepted start.

Top module: `pll_srch`

## Requirements
- R1: While reset is asserted and after it is released, busy, done, M, N, PL, the achieved rate, the exact flag and the no-candidate flag are all zero.
- R2: A start pulse seen while idle raises busy on the next cycle. done is a single-cycle pulse in the cycle in which busy falls. A start pulse seen while busy is ignored, and the result reflects only the accepted request.
- R3: A PL code selects a post-divide ratio. Codes 0 to 14 give 1, 2, 3, 4, 5, 6, 8, 10, 12, 16, 12, 16, 20, 24 and 32, and any other code gives 1. The reported PL is always a code in 0 to 14.
- R4: The internal target T is twice the request. The provisional VCO target is T + floor(T/50), and the upper VCO limit is the larger of the VCO maximum and this value. The highest PL tried is the code for ceil(upper limit / provisional target). The lowest PL tried is the code for floor(VCO minimum / provisional target). Each ratio is clamped to 1..32 first, and a ratio is turned into the first code, counting up from 0, whose ratio is at least that value (code 14 if none is).
- R5: PL codes are tried from low to high. Within each code, M counts up from its minimum (1). If reference/M falls below the minimum comparison frequency (12,000), the M loop for that code ends. An M giving more than the maximum (38,000) is skipped. M never exceeds 255.
- R6: For each M, N runs from floor(T·ratio·M/ref) to its ceiling. If the floor exceeds the N maximum (255), the M loop ends. N below 8 is skipped and N above 255 ends the N loop. A candidate counts only when floor(ref·N/M) lies between 1,000,000 and the upper VCO limit.
- R7: A candidate's error is |round(VCO/ratio) − T|, rounding half up. The best candidate is replaced only on a strictly smaller error, and the search stops at the first zero error. The exact flag is high exactly when the final error is zero.
- R8: Until a candidate counts, the result is M = 255, N = 8 and a PL code equal to the minimum ratio value (1). If none counts, the no-candidate flag is high and the exact flag is low.
- R9: The achieved rate is floor(floor(ref·N / (M·ratio(PL))) / 2).
- R10: The reported M, N, PL, rate and flags change only in the cycle in which done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search (accepted when idle) |
| req_khz | input | W | Requested output rate in kHz, at least 1 |
| ref_khz | input | W | Reference clock rate in kHz, nonzero |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| m_out | output | MW | Chosen reference divider M |
| n_out | output | MW | Chosen feedback multiplier N |
| pl_out | output | 4 | Chosen post-divider code |
| rate_khz | output | W | Achieved output rate in kHz |
| exact | output | 1 | Best error is zero |
| none_found | output | 1 | No candidate was valid |

## Verification
The bench builds two copies. The first uses the default limits with a 32-bit datapath, so that a sweep over three reference rates and eight requests, from very low to beyond the VCO maximum, can be compared against an arithmetic model of the search in the bench. That sweep covers exact hits, inexact best fits, the widened VCO ceiling and a request too low for any valid VCO. The second copy raises the minimum comparison frequency above every reference used. This ends the M loop at once, which makes the default result and the no-candidate flag observable, and it tests start pulses ignored during a search.

// File: rtl/pll_srch_pkg.sv
package pll_srch_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_VT, S_HI, S_LO, S_PL, S_MU, S_MN, S_NCHK, S_NVCO, S_NLWV, S_FIN
  } srch_state_e;

  // post-divider code to divide ratio; non-monotonic above code 9
  function automatic logic [5:0] code_ratio(input logic [4:0] code);
    logic [5:0] r;
    case (code)
      5'd0:  r = 6'd1;
      5'd1:  r = 6'd2;
      5'd2:  r = 6'd3;
      5'd3:  r = 6'd4;
      5'd4:  r = 6'd5;
      5'd5:  r = 6'd6;
      5'd6:  r = 6'd8;
      5'd7:  r = 6'd10;
      5'd8:  r = 6'd12;
      5'd9:  r = 6'd16;
      5'd10: r = 6'd12;
      5'd11: r = 6'd16;
      5'd12: r = 6'd20;
      5'd13: r = 6'd24;
      5'd14: r = 6'd32;
      default: r = 6'd1;
    endcase
    return r;
  endfunction

  // smallest code (scanning upward) whose ratio reaches r, else the top code
  function automatic logic [3:0] ratio_code(input logic [5:0] r);
    logic [3:0] c;
    c = 4'd14;
    for (int i = 13; i >= 0; i--) begin
      if (code_ratio(5'(i)) >= r) c = 4'(i);
    end
    return c;
  endfunction

endpackage

// File: rtl/pll_srch_div.sv
module pll_srch_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  q_r, r_r, d_r;
  logic [CW-1:0] cnt;
  logic          run, done_r;
  logic [W:0]    shifted;
  logic          fits;

  assign shifted = {r_r, q_r[W-1]};
  assign fits    = shifted >= {1'b0, d_r};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_r    <= '0;
      r_r    <= '0;
      d_r    <= '0;
      cnt    <= '0;
      run    <= 1'b0;
      done_r <= 1'b0;
    end else begin
      done_r <= 1'b0;
      if (go && !run) begin
        q_r <= num;
        r_r <= '0;
        d_r <= den;
        cnt <= CW'(W);
        run <= 1'b1;
      end else if (run) begin
        if (fits) begin
          r_r <= W'(shifted - {1'b0, d_r});
          q_r <= {q_r[W-2:0], 1'b1};
        end else begin
          r_r <= shifted[W-1:0];
          q_r <= {q_r[W-2:0], 1'b0};
        end
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          run    <= 1'b0;
          done_r <= 1'b1;
        end
      end
    end
  end

  assign busy = run;
  assign done = done_r;
  assign quo  = q_r;
  assign rem  = r_r;
endmodule

// File: rtl/pll_srch_rng.sv
module pll_srch_rng #(
  parameter int W       = 32,
  parameter int MIN_DIV = 1,
  parameter int MAX_DIV = 32
) (
  input  logic [W-1:0] ratio_in,
  output logic [3:0]   code
);
  import pll_srch_pkg::*;

  logic [W-1:0] lo_cl, hi_cl;

  always_comb begin
    lo_cl = (ratio_in > W'(MAX_DIV)) ? W'(MAX_DIV) : ratio_in;
    hi_cl = (lo_cl < W'(MIN_DIV)) ? W'(MIN_DIV) : lo_cl;
    code  = ratio_code(hi_cl[5:0]);
  end
endmodule

// File: rtl/pll_srch_score.sv
module pll_srch_score #(
  parameter int W = 32
) (
  input  logic [W-1:0] lwv,
  input  logic [W-1:0] target,
  input  logic [W-1:0] best,
  output logic [W-1:0] delta,
  output logic         better,
  output logic         hit
);
  always_comb begin
    delta  = (lwv >= target) ? (lwv - target) : (target - lwv);
    better = delta < best;
    hit    = better && (delta == '0);
  end
endmodule

// File: rtl/pll_srch.sv
module pll_srch #(
  parameter int W       = 32,
  parameter int MW      = 8,
  parameter int MIN_VCO = 1000000,
  parameter int MAX_VCO = 2064000,
  parameter int MIN_U   = 12000,
  parameter int MAX_U   = 38000,
  parameter int MIN_M   = 1,
  parameter int MAX_M   = 255,
  parameter int MIN_N   = 8,
  parameter int MAX_N   = 255,
  parameter int MIN_DIV = 1,
  parameter int MAX_DIV = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [W-1:0]  req_khz,
  input  logic [W-1:0]  ref_khz,
  output logic          busy,
  output logic          done,
  output logic [MW-1:0] m_out,
  output logic [MW-1:0] n_out,
  output logic [3:0]    pl_out,
  output logic [W-1:0]  rate_khz,
  output logic          exact,
  output logic          none_found
);
  import pll_srch_pkg::*;

  localparam int MCW = MW + 1;

  srch_state_e st;
  logic          launched;
  logic [W-1:0]  ref_r, target, vt, maxv, tv, vco, n_hi, nc;
  logic [3:0]    hi_code;
  logic [4:0]    pl;
  logic [MCW-1:0] m;
  logic [MW-1:0] best_m, best_n;
  logic [3:0]    best_pl;
  logic [W-1:0]  best_d;
  logic          done_r;

  logic [W-1:0]  dv_num, dv_den, dv_q, dv_r;
  logic          dv_busy;
  logic          is_div, m_over;
  logic [5:0]    ratio_pl, ratio_best;
  logic [W-1:0]  vt_next;
  logic [3:0]    rng_code;
  logic [W-1:0]  sc_delta;
  logic          sc_better, sc_hit;

  // named internal events
  logic ev_go, ev_dv_done, ev_improve, ev_exact_hit, ev_finish;

  assign ratio_pl   = code_ratio(pl);
  assign ratio_best = code_ratio({1'b0, best_pl});
  assign vt_next    = target + dv_q;
  assign m_over     = m > MCW'(MAX_M);

  always_comb begin
    is_div = 1'b1;
    dv_num = '0;
    dv_den = W'(1);
    case (st)
      S_VT:   begin dv_num = target;                dv_den = W'(50); end
      S_HI:   begin dv_num = maxv + vt - W'(1);     dv_den = vt; end
      S_LO:   begin dv_num = W'(MIN_VCO);           dv_den = vt; end
      S_MU:   begin dv_num = ref_r;                 dv_den = W'(m); end
      S_MN:   begin dv_num = tv * W'(m);            dv_den = ref_r; end
      S_NVCO: begin dv_num = ref_r * nc;            dv_den = W'(m); end
      S_NLWV: begin dv_num = vco + W'(ratio_pl >> 1); dv_den = W'(ratio_pl); end
      S_FIN:  begin dv_num = ref_r * W'(best_n);    dv_den = W'(best_m) * W'(ratio_best); end
      default: is_div = 1'b0;
    endcase
  end

  assign ev_go        = is_div && !launched && !(st == S_MU && m_over);
  assign ev_improve   = (st == S_NLWV) && ev_dv_done && sc_better;
  assign ev_exact_hit = (st == S_NLWV) && ev_dv_done && sc_hit;
  assign ev_finish    = (st == S_FIN) && ev_dv_done;

  pll_srch_div #(.W(W)) u_div (
    .clk(clk), .rst_n(rst_n), .go(ev_go), .num(dv_num), .den(dv_den),
    .busy(dv_busy), .done(ev_dv_done), .quo(dv_q), .rem(dv_r)
  );

  pll_srch_rng #(.W(W), .MIN_DIV(MIN_DIV), .MAX_DIV(MAX_DIV)) u_rng (
    .ratio_in(dv_q), .code(rng_code)
  );

  pll_srch_score #(.W(W)) u_score (
    .lwv(dv_q), .target(target), .best(best_d),
    .delta(sc_delta), .better(sc_better), .hit(sc_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      launched <= 1'b0;
    end else if (ev_go) begin
      launched <= 1'b1;
    end else if (ev_dv_done) begin
      launched <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      ref_r      <= '0;
      target     <= '0;
      vt         <= '0;
      maxv       <= '0;
      tv         <= '0;
      vco        <= '0;
      n_hi       <= '0;
      nc         <= '0;
      hi_code    <= '0;
      pl         <= '0;
      m          <= '0;
      best_m     <= '0;
      best_n     <= '0;
      best_pl    <= '0;
      best_d     <= '0;
      done_r     <= 1'b0;
      m_out      <= '0;
      n_out      <= '0;
      pl_out     <= '0;
      rate_khz   <= '0;
      exact      <= 1'b0;
      none_found <= 1'b0;
    end else begin
      done_r <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            ref_r   <= ref_khz;
            target  <= req_khz << 1;
            best_m  <= MW'(MAX_M);
            best_n  <= MW'(MIN_N);
            best_pl <= 4'(MIN_DIV);
            best_d  <= '1;
            st      <= S_VT;
          end
        end
        S_VT: if (ev_dv_done) begin
          vt   <= vt_next;
          maxv <= (W'(MAX_VCO) > vt_next) ? W'(MAX_VCO) : vt_next;
          st   <= S_HI;
        end
        S_HI: if (ev_dv_done) begin
          hi_code <= rng_code;
          st      <= S_LO;
        end
        S_LO: if (ev_dv_done) begin
          pl <= {1'b0, rng_code};
          st <= S_PL;
        end
        S_PL: begin
          if (pl > {1'b0, hi_code}) begin
            st <= S_FIN;
          end else begin
            tv <= target * W'(ratio_pl);
            m  <= MCW'(MIN_M);
            st <= S_MU;
          end
        end
        S_MU: begin
          if (m_over) begin
            pl <= pl + 1'b1;
            st <= S_PL;
          end else if (ev_dv_done) begin
            if (dv_q < W'(MIN_U)) begin
              pl <= pl + 1'b1;
              st <= S_PL;
            end else if (dv_q > W'(MAX_U)) begin
              m <= m + 1'b1;
            end else begin
              st <= S_MN;
            end
          end
        end
        S_MN: if (ev_dv_done) begin
          if (dv_q > W'(MAX_N)) begin
            pl <= pl + 1'b1;
            st <= S_PL;
          end else begin
            nc   <= dv_q;
            n_hi <= dv_q + W'(dv_r != '0);
            st   <= S_NCHK;
          end
        end
        S_NCHK: begin
          if (nc > n_hi || nc > W'(MAX_N)) begin
            m  <= m + 1'b1;
            st <= S_MU;
          end else if (nc < W'(MIN_N)) begin
            nc <= nc + 1'b1;
          end else begin
            st <= S_NVCO;
          end
        end
        S_NVCO: if (ev_dv_done) begin
          vco <= dv_q;
          if (dv_q >= W'(MIN_VCO) && dv_q <= maxv) begin
            st <= S_NLWV;
          end else begin
            nc <= nc + 1'b1;
            st <= S_NCHK;
          end
        end
        S_NLWV: if (ev_dv_done) begin
          if (sc_better) begin
            best_d  <= sc_delta;
            best_m  <= m[MW-1:0];
            best_n  <= nc[MW-1:0];
            best_pl <= pl[3:0];
          end
          if (sc_hit) begin
            st <= S_FIN;
          end else begin
            nc <= nc + 1'b1;
            st <= S_NCHK;
          end
        end
        S_FIN: if (ev_dv_done) begin
          m_out      <= best_m;
          n_out      <= best_n;
          pl_out     <= best_pl;
          rate_khz   <= dv_q >> 1;
          exact      <= best_d == '0;
          none_found <= &best_d;
          done_r     <= 1'b1;
          st         <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy = (st != S_IDLE);
  assign done = done_r;
endmodule

// File: rtl/pll_srch_chk.sv
module pll_srch_chk #(
  parameter int W     = 32,
  parameter int MW    = 8,
  parameter int MIN_M = 1,
  parameter int MAX_M = 255,
  parameter int MIN_N = 8,
  parameter int MAX_N = 255
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [MW-1:0] m_out,
  input logic [MW-1:0] n_out,
  input logic [3:0]    pl_out,
  input logic [W-1:0]  rate_khz,
  input logic          exact,
  input logic          none_found,
  input logic          ev_go,
  input logic          ev_dv_done
);
  localparam int LCW = $clog2(W + 2) + 1;
  logic [LCW-1:0] lat;

  always_ff @(posedge clk) begin
    if (!rst_n) lat <= '0;
    else if (ev_go) lat <= LCW'(1);
    else if (ev_dv_done) lat <= '0;
    else if (lat != '0) lat <= lat + 1'b1;
  end

  a_r2_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r2_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(m_out) && $stable(n_out) && $stable(pl_out)
               && $stable(rate_khz) && $stable(exact) && $stable(none_found)));
  a_r7_flags: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(exact && none_found));
  a_r5_m_range: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (m_out >= MW'(MIN_M) && m_out <= MW'(MAX_M)));
  a_r6_n_range: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (n_out >= MW'(MIN_N) && n_out <= MW'(MAX_N)));
  a_r3_pl_code: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> pl_out <= 4'd14);
  a_r9_div_latency: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dv_done |-> lat == LCW'(W + 1));
endmodule

bind pll_srch pll_srch_chk #(
  .W(W), .MW(MW), .MIN_M(MIN_M), .MAX_M(MAX_M), .MIN_N(MIN_N), .MAX_N(MAX_N)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .m_out(m_out), .n_out(n_out), .pl_out(pl_out), .rate_khz(rate_khz),
  .exact(exact), .none_found(none_found), .ev_go(ev_go), .ev_dv_done(ev_dv_done)
);

// File: tb/pll_srch_tb.sv
module pll_srch_tb;
  localparam int W  = 32;
  localparam int MW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic st_a = 1'b0, st_b = 1'b0;
  logic [W-1:0] rq_a = '0, rf_a = '0, rq_b = '0, rf_b = '0;
  logic busy_a, done_a, ex_a, nf_a, busy_b, done_b, ex_b, nf_b;
  logic [MW-1:0] m_a, n_a, m_b, n_b;
  logic [3:0] pl_a, pl_b;
  logic [W-1:0] rate_a, rate_b;

  pll_srch #(.W(W), .MW(MW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(st_a), .req_khz(rq_a), .ref_khz(rf_a),
    .busy(busy_a), .done(done_a), .m_out(m_a), .n_out(n_a), .pl_out(pl_a),
    .rate_khz(rate_a), .exact(ex_a), .none_found(nf_a));

  pll_srch #(.W(W), .MW(MW), .MIN_U(40000)) u_dut_nf (
    .clk(clk), .rst_n(rst_n), .start(st_b), .req_khz(rq_b), .ref_khz(rf_b),
    .busy(busy_b), .done(done_b), .m_out(m_b), .n_out(n_b), .pl_out(pl_b),
    .rate_khz(rate_b), .exact(ex_b), .none_found(nf_b));

  int n_chk = 0, n_bad = 0;
  logic sel = 1'b0;

  wire o_busy = sel ? busy_b : busy_a;
  wire o_done = sel ? done_b : done_a;
  wire o_ex   = sel ? ex_b : ex_a;
  wire o_nf   = sel ? nf_b : nf_a;
  wire [MW-1:0] o_m = sel ? m_b : m_a;
  wire [MW-1:0] o_n = sel ? n_b : n_a;
  wire [3:0] o_pl = sel ? pl_b : pl_a;
  wire [W-1:0] o_rate = sel ? rate_b : rate_a;

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic longint rat(input longint c);
    longint tbl [15] = '{1, 2, 3, 4, 5, 6, 8, 10, 12, 16, 12, 16, 20, 24, 32};
    if (c < 0 || c > 14) return 1;
    return tbl[c];
  endfunction

  function automatic longint code_of(input longint r);
    for (int c = 0; c < 14; c++) if (rat(c) >= r) return c;
    return 14;
  endfunction

  function automatic longint clampr(input longint r);
    if (r > 32) return 32;
    if (r < 1) return 1;
    return r;
  endfunction

  task automatic model(input longint rq, input longint rf, input longint minu,
                       output longint em, output longint en, output longint ep,
                       output longint erate, output bit eex, output bit enone);
    longint tgt, vt, mx, hi, lo, bd, bm, bn, bp, tv, u, nl, nh, v, l, d;
    bit stop;
    tgt = 2 * rq;
    vt  = tgt + tgt / 50;
    mx  = (vt > 2064000) ? vt : 2064000;
    hi  = code_of(clampr((mx + vt - 1) / vt));
    lo  = code_of(clampr(1000000 / vt));
    bd = 64'hFFFF_FFFF; bm = 255; bn = 8; bp = 1; stop = 0;
    for (longint p = lo; p <= hi && !stop; p++) begin
      tv = tgt * rat(p);
      for (longint m = 1; m <= 255 && !stop; m++) begin
        u = rf / m;
        if (u < minu) break;
        if (u > 38000) continue;
        nl = (tv * m) / rf;
        nh = (tv * m + rf - 1) / rf;
        if (nl > 255) break;
        for (longint k = nl; k <= nh && !stop; k++) begin
          if (k < 8) continue;
          if (k > 255) break;
          v = rf * k / m;
          if (v >= 1000000 && v <= mx) begin
            l = (v + rat(p) / 2) / rat(p);
            d = (l > tgt) ? l - tgt : tgt - l;
            if (d < bd) begin
              bd = d; bm = m; bn = k; bp = p;
              if (d == 0) stop = 1;
            end
          end
        end
      end
    end
    em = bm; en = bn; ep = bp;
    erate = ((rf * bn) / (bm * rat(bp))) / 2;
    eex = (bd == 0);
    enone = (bd == 64'hFFFF_FFFF);
  endtask

  task automatic run(input bit b, input longint rq, input longint rf, input bit poke);
    longint em, en, ep, erate;
    bit eex, enone;
    int t;
    model(rq, rf, b ? 40000 : 12000, em, en, ep, erate, eex, enone);
    sel = b;
    @(negedge clk);
    if (b) begin rq_b = W'(rq); rf_b = W'(rf); st_b = 1'b1; end
    else   begin rq_a = W'(rq); rf_a = W'(rf); st_a = 1'b1; end
    @(negedge clk);
    st_a = 1'b0; st_b = 1'b0;
    chk(o_busy === 1'b1, "R2 busy after start", longint'(o_busy), 1);
    if (poke) begin
      if (b) begin rq_b = W'(rq + 777); st_b = 1'b1; end
      else   begin rq_a = W'(rq + 777); st_a = 1'b1; end
      @(negedge clk);
      st_a = 1'b0; st_b = 1'b0;
    end
    t = 0;
    while (o_done !== 1'b1 && t < 20000) begin
      @(negedge clk);
      t++;
    end
    chk(t < 20000, "R2 search completes", t, 0);
    chk(o_busy === 1'b0, "R2 busy low with done", longint'(o_busy), 0);
    chk(o_m == MW'(em), "R5 M", o_m, em);
    chk(o_n == MW'(en), "R6 N", o_n, en);
    chk(o_pl == 4'(ep), "R3 R4 PL code", o_pl, ep);
    chk(o_rate == W'(erate), "R9 achieved rate", o_rate, erate);
    chk(o_ex == eex, "R7 exact flag", longint'(o_ex), longint'(eex));
    chk(o_nf == enone, "R8 no-candidate flag", longint'(o_nf), longint'(enone));
    @(negedge clk);
    chk(o_done === 1'b0, "R2 done single cycle", longint'(o_done), 0);
    repeat (3) @(negedge clk);
    chk(o_m == MW'(em) && o_n == MW'(en) && o_rate == W'(erate),
        "R10 result held", o_rate, erate);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R2 watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    longint refs [3] = '{12000, 19200, 38400};
    longint reqs [8] = '{36000, 54000, 126000, 306000, 426000, 998400, 1500000, 5000};
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy_a === 1'b0 && done_a === 1'b0, "R1 busy/done in reset", longint'(busy_a), 0);
    chk(m_a == '0 && n_a == '0 && pl_a == '0 && rate_a == '0 && !ex_a && !nf_a,
        "R1 outputs in reset", rate_a, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy_a === 1'b0 && m_a == '0 && rate_a == '0, "R1 outputs after reset", m_a, 0);
    for (int r = 0; r < 3; r++) begin
      for (int q = 0; q < 8; q++) begin
        run(1'b0, reqs[q], refs[r], (r == 2 && q == 3));
      end
    end
    // R8 defaults with an unreachable comparison-frequency floor
    run(1'b1, 306000, 38400, 1'b0);
    run(1'b1, 90000, 19200, 1'b1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule